// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Interface

This block is the device end of a three-wire serial memory link. A host drives chip select, a serial clock and a data input. The block drives a data output that it can switch to high impedance. All serial inputs are oversampled by a free-running system clock. Each instruction opens with a start bit, then carries a two-bit opcode and an address. Write-type instructions also carry a data field. The block supports reading, writing and erasing one location, erasing or writing the whole array, and setting or clearing a write-enable latch. The storage is a register array of 2^WADDR_W words of WORD_W bits. When the byte strap is high, the same array is addressed as twice as many bytes.

A write-type instruction starts an internal programming cycle when chip select falls after the last bit of the frame. The programming time is set by a parameter and counted in system clocks. After the cycle starts, the host raises chip select again and polls the data output: it reads low while the cycle runs and high once it is done. Clocking a one into the data input while this status is shown releases the output. After that the block accepts the next instruction.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data output is released (enable low) and the write-enable latch is clear, so a write-type frame sent straight after reset starts no programming cycle and shows no status.
- R2: READ (start 1, opcode 10, address) drives a 0 on the data output after the last address bit is sampled. The data word then follows MSB first, one new bit after each rising serial clock edge. The rising edge after the last data bit releases the output.
- R3: WRITE (start 1, opcode 01, address, data) with the latch set stores the data at the address. Its programming cycle begins when chip select falls after the complete frame.
- R4: With the latch clear, WRITE, ERASE, erase-all and write-all leave the array unchanged and start no programming cycle, so raising chip select afterwards shows no status.
- R5: ERASE (start 1, opcode 11, address) with the latch set makes the addressed word all ones and leaves other words unchanged.
- R6: With opcode 00, the two most significant address bits select a special command. Code 11 sets the write-enable latch and code 00 clears it. The remaining address bits are ignored.
- R7: With opcode 00, code 10 erases every word to all ones. Code 01 is followed by a data field and writes that data to every word. Both need the latch set.
- R8: With the byte strap high, the address is 9 bits and the data field is 8 bits. Byte address 2k maps to the low half of word k and 2k+1 to the high half.
- R9: While a programming cycle runs, raising chip select drives the output low. The output goes high once the cycle ends. The cycle lasts max(BUSY_CYCLES, 2^WADDR_W) system clocks, counted from the chip select fall plus a few clocks of input synchronisation.
- R10: While status is shown, a 1 sampled on a rising serial clock edge releases the output. That bit is not taken as a start bit. No instruction is accepted while busy or before that release.
- R11: Lowering chip select in the middle of a frame discards it with no effect. The next start bit begins a fresh frame.
- R12: The data output is enabled only while chip select is high and the block is either shifting read data or showing status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| org_x8 | input | 1 | Byte organisation strap (1 = 8-bit words) |
| cs_i | input | 1 | Chip select from host |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data value toward host |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |

## Verification
The bench builds the block with its default 16-bit words and 256-word array, two synchroniser stages, and BUSY_CYCLES lowered to 400. Because 400 exceeds the word count, the busy window is set by the parameter rather than by the bulk sweep, so its length can be measured exactly. The window is still short enough for a run to cover many write, erase, erase-all and write-all cycles. A serial half period of eight system clocks leaves room for the synchroniser and output register latency before each sample. The byte strap is toggled in the same run, so the byte and word views of one location are compared against each other.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // instruction opcodes after the start bit
  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  // special command codes carried in the two top address bits
  localparam logic [1:0] SPC_LOCK    = 2'b00;
  localparam logic [1:0] SPC_FILL    = 2'b01;
  localparam logic [1:0] SPC_WIPE    = 2'b10;
  localparam logic [1:0] SPC_UNLOCK  = 2'b11;

  typedef enum logic [1:0] {
    PK_WRITE,
    PK_ERASE,
    PK_WIPE,
    PK_FILL
  } prog_kind_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_OPC,
    FS_ADDR,
    FS_DATA,
    FS_RDOUT,
    FS_HOLD
  } frame_st_e;
endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_raw,
  input  logic sk_raw,
  input  logic di_raw,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_fall
);
  logic [2:0] chain [STAGES];
  logic       sk_prev;
  logic       cs_prev;
  logic       sk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      chain[0] <= {cs_raw, sk_raw, di_raw};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sk_prev <= sk_s;
      cs_prev <= cs_s;
    end
  end

  assign cs_s    = chain[STAGES-1][2];
  assign sk_s    = chain[STAGES-1][1];
  assign di_s    = chain[STAGES-1][0];
  assign sk_rise = sk_s & ~sk_prev;
  assign cs_fall = ~cs_s & cs_prev;
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               org_x8,
  input  logic               cs_s,
  input  logic               cs_fall,
  input  logic               sk_rise,
  input  logic               di_s,
  input  logic               allow,
  input  logic [WORD_W-1:0]  rd_word,
  output logic               rd_req,
  output logic [WADDR_W:0]   fr_addr,
  output logic [WORD_W-1:0]  fr_data,
  output prog_kind_e         fr_kind,
  output logic               fr_done,
  output logic               ewen_p,
  output logic               ewds_p,
  output logic               out_en,
  output logic               out_bit
);
  localparam int BADDR_W = WADDR_W + 1;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int CW      = $clog2(WORD_W + 2);

  frame_st_e         st;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic              pend;
  logic              ld;
  logic [WORD_W-1:0] sh;

  logic [CW-1:0]      aw_last;
  logic [CW-1:0]      dw_last;
  logic [BADDR_W-1:0] addr_nx;
  logic [1:0]         top2;

  always_comb begin
    aw_last = org_x8 ? CW'(BADDR_W - 1) : CW'(WADDR_W - 1);
    dw_last = org_x8 ? CW'(BYTE_W - 1)  : CW'(WORD_W - 1);
    addr_nx = {fr_addr[BADDR_W-2:0], di_s};
    top2    = org_x8 ? addr_nx[BADDR_W-1 -: 2] : addr_nx[WADDR_W-1 -: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      opc     <= '0;
      fr_addr <= '0;
      fr_data <= '0;
      fr_kind <= PK_WRITE;
      pend    <= 1'b0;
      fr_done <= 1'b0;
      ewen_p  <= 1'b0;
      ewds_p  <= 1'b0;
      rd_req  <= 1'b0;
      ld      <= 1'b0;
      sh      <= '0;
      out_en  <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      ewen_p  <= 1'b0;
      ewds_p  <= 1'b0;
      rd_req  <= 1'b0;
      fr_done <= cs_fall & pend;
      ld      <= rd_req;
      if (ld) begin
        sh <= org_x8 ? {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}} : rd_word;
      end
      if (!cs_s) begin
        st      <= FS_IDLE;
        pend    <= 1'b0;
        out_en  <= 1'b0;
        out_bit <= 1'b0;
      end else if (sk_rise) begin
        unique case (st)
          FS_IDLE: begin
            if (di_s && allow) begin
              st  <= FS_OPC;
              cnt <= '0;
            end
          end
          FS_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CW'(1)) begin
              st  <= FS_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_ADDR: begin
            fr_addr <= addr_nx;
            if (cnt == aw_last) begin
              cnt <= '0;
              unique case (opc)
                OPC_READ: begin
                  st      <= FS_RDOUT;
                  rd_req  <= 1'b1;
                  out_en  <= 1'b1;
                  out_bit <= 1'b0;
                end
                OPC_WRITE: begin
                  st      <= FS_DATA;
                  fr_kind <= PK_WRITE;
                end
                OPC_ERASE: begin
                  st      <= FS_HOLD;
                  fr_kind <= PK_ERASE;
                  pend    <= 1'b1;
                end
                default: begin
                  unique case (top2)
                    SPC_UNLOCK: begin
                      st     <= FS_HOLD;
                      ewen_p <= 1'b1;
                    end
                    SPC_LOCK: begin
                      st     <= FS_HOLD;
                      ewds_p <= 1'b1;
                    end
                    SPC_WIPE: begin
                      st      <= FS_HOLD;
                      fr_kind <= PK_WIPE;
                      pend    <= 1'b1;
                    end
                    default: begin
                      st      <= FS_DATA;
                      fr_kind <= PK_FILL;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_DATA: begin
            fr_data <= {fr_data[WORD_W-2:0], di_s};
            if (cnt == dw_last) begin
              st   <= FS_HOLD;
              pend <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_RDOUT: begin
            if (cnt == dw_last + 1'b1) begin
              st      <= FS_HOLD;
              out_en  <= 1'b0;
              out_bit <= 1'b0;
            end else begin
              out_bit <= sh[WORD_W-1];
              sh      <= {sh[WORD_W-2:0], 1'b0};
              cnt     <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int WORD_W  = 16,
  parameter int WADDR_W = 8
) (
  input  logic               clk,
  input  logic               org_x8,
  input  logic               rd_en,
  input  logic [WADDR_W:0]   rd_baddr,
  output logic [WORD_W-1:0]  rd_word,
  input  logic               we_lo,
  input  logic               we_hi,
  input  logic [WADDR_W-1:0] w_addr,
  input  logic [WORD_W-1:0]  w_data
);
  localparam int WORDS  = 1 << WADDR_W;
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0]  lo_mem [WORDS];
  logic [BYTE_W-1:0]  hi_mem [WORDS];
  logic [BYTE_W-1:0]  lo_q;
  logic [BYTE_W-1:0]  hi_q;
  logic               sel_q;
  logic [WADDR_W-1:0] r_word;

  assign r_word = org_x8 ? rd_baddr[WADDR_W:1] : rd_baddr[WADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (we_lo) lo_mem[w_addr] <= w_data[BYTE_W-1:0];
    if (rd_en) lo_q <= lo_mem[r_word];
  end

  always_ff @(posedge clk) begin
    if (we_hi) hi_mem[w_addr] <= w_data[WORD_W-1:BYTE_W];
    if (rd_en) hi_q <= hi_mem[r_word];
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= org_x8 & rd_baddr[0];
  end

  assign rd_word = org_x8 ? {{BYTE_W{1'b0}}, (sel_q ? hi_q : lo_q)} : {hi_q, lo_q};
endmodule

// File: rtl/mw_prog.sv
module mw_prog
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WADDR_W     = 8,
  parameter int BUSY_CYCLES = 1200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               org_x8,
  input  logic               go,
  input  prog_kind_e         kind,
  input  logic [WADDR_W:0]   baddr,
  input  logic [WORD_W-1:0]  data,
  output logic               busy,
  output logic               we_lo,
  output logic               we_hi,
  output logic [WADDR_W-1:0] w_addr,
  output logic [WORD_W-1:0]  w_data
);
  localparam int WORDS     = 1 << WADDR_W;
  localparam int BYTE_W    = WORD_W / 2;
  localparam int OP_CYCLES = (BUSY_CYCLES > WORDS) ? BUSY_CYCLES : WORDS;
  localparam int TW        = $clog2(OP_CYCLES + 1);

  logic [TW-1:0]      tick;
  prog_kind_e         k_q;
  logic [WADDR_W:0]   a_q;
  logic [WORD_W-1:0]  d_q;
  logic               bulk;
  logic               act;
  logic [WADDR_W-1:0] one_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tick <= '0;
      k_q  <= PK_WRITE;
      a_q  <= '0;
      d_q  <= '0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      tick <= '0;
      k_q  <= kind;
      a_q  <= baddr;
      d_q  <= data;
    end else if (busy) begin
      if (tick == TW'(OP_CYCLES - 1)) busy <= 1'b0;
      else tick <= tick + 1'b1;
    end
  end

  always_comb begin
    bulk     = (k_q == PK_WIPE) || (k_q == PK_FILL);
    one_word = org_x8 ? a_q[WADDR_W:1] : a_q[WADDR_W-1:0];
    act      = busy && (bulk ? (tick < TW'(WORDS)) : (tick == '0));
    w_addr   = bulk ? tick[WADDR_W-1:0] : one_word;
    if (k_q == PK_ERASE || k_q == PK_WIPE) w_data = '1;
    else if (org_x8) w_data = {d_q[BYTE_W-1:0], d_q[BYTE_W-1:0]};
    else w_data = d_q;
    if (org_x8 && !bulk) begin
      we_lo = act & ~a_q[0];
      we_hi = act &  a_q[0];
    end else begin
      we_lo = act;
      we_hi = act;
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WADDR_W     = 8,
  parameter int BUSY_CYCLES = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic org_x8,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic               cs_s, di_s, sk_rise, cs_fall;
  logic               rd_req, fr_done, ewen_p, ewds_p, pr_out_en, pr_out_bit;
  logic [WADDR_W:0]   fr_addr;
  logic [WORD_W-1:0]  fr_data, rd_word, w_data;
  prog_kind_e         fr_kind;
  logic               busy, we_lo, we_hi;
  logic [WADDR_W-1:0] w_addr;
  logic               wen_q, armed_q, armed_nx, allow, go;

  mw_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .cs_raw(cs_i), .sk_raw(sck_i), .di_raw(sdi_i),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_frame #(.WORD_W(WORD_W), .WADDR_W(WADDR_W)) frame_i (
    .clk(clk), .rst(rst), .org_x8(org_x8), .cs_s(cs_s), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di_s(di_s), .allow(allow), .rd_word(rd_word),
    .rd_req(rd_req), .fr_addr(fr_addr), .fr_data(fr_data), .fr_kind(fr_kind),
    .fr_done(fr_done), .ewen_p(ewen_p), .ewds_p(ewds_p),
    .out_en(pr_out_en), .out_bit(pr_out_bit)
  );

  mw_store #(.WORD_W(WORD_W), .WADDR_W(WADDR_W)) store_i (
    .clk(clk), .org_x8(org_x8), .rd_en(rd_req), .rd_baddr(fr_addr),
    .rd_word(rd_word), .we_lo(we_lo), .we_hi(we_hi), .w_addr(w_addr),
    .w_data(w_data)
  );

  mw_prog #(.WORD_W(WORD_W), .WADDR_W(WADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) prog_i (
    .clk(clk), .rst(rst), .org_x8(org_x8), .go(go), .kind(fr_kind),
    .baddr(fr_addr), .data(fr_data), .busy(busy), .we_lo(we_lo),
    .we_hi(we_hi), .w_addr(w_addr), .w_data(w_data)
  );

  always_comb begin
    go    = fr_done & wen_q;
    allow = ~busy & ~armed_q;
    if (go) armed_nx = 1'b1;
    else if (armed_q && cs_s && sk_rise && di_s) armed_nx = 1'b0;
    else armed_nx = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q    <= 1'b0;
      armed_q  <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (ewen_p) wen_q <= 1'b1;
      else if (ewds_p) wen_q <= 1'b0;
      armed_q  <= armed_nx;
      sdo_oe_o <= cs_s & (armed_nx | pr_out_en);
      sdo_o    <= armed_nx ? ~busy : pr_out_bit;
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic sk_rise,
  input logic di_s,
  input logic busy,
  input logic wen,
  input logic armed,
  input logic sdo_oe,
  input logic rd_out_en
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state right after reset
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      a_r1_reset_state: assert (!sdo_oe && !wen && !armed && !busy);
    end
  end

  // R3: programming begins only after chip select has dropped
  a_r3_start_on_cs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !cs_s);

  // R4: no programming without the latch
  a_r4_needs_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wen));

  // R6: latch is frozen while a programming cycle runs
  a_r6_latch_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wen));

  // R10: a clocked 1 during status clears the status
  a_r10_dummy_releases: assert property (@(posedge clk) disable iff (rst)
    (armed && cs_s && sk_rise && di_s && !busy) |=> !armed);

  // R12: output released whenever chip select is low
  a_r12_hiz_cs_low: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_oe);

  // R11: parser drops read output when chip select is low
  a_r11_abort_parser: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !rd_out_en);
endmodule

bind mw_eeprom mw_eeprom_chk chk_i (
  .clk(clk), .rst(rst), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
  .busy(busy), .wen(wen_q), .armed(armed_q), .sdo_oe(sdo_oe_o),
  .rd_out_en(pr_out_en)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int H    = 8;
  localparam int BUSY = 400;
  localparam int OPCY = 400;
  localparam int NV   = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_0001, 24'h20_8000, 24'h41_A5A5,
    24'h7F_FFFE, 24'hC3_0F0F, 24'hFF_5AC3
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, org_x8, cs, sk, di;
  logic sdo, sdo_oe;
  int   errs = 0;
  int   checks = 0;
  bit   done = 0;

  mw_eeprom #(.WORD_W(16), .WADDR_W(8), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .org_x8(org_x8), .cs_i(cs), .sck_i(sk), .sdi_i(di),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int aw();
    return org_x8 ? 9 : 8;
  endfunction
  function automatic int dw();
    return org_x8 ? 8 : 16;
  endfunction

  task automatic bitc(input logic b);
    @(negedge clk); sk = 1'b0; di = b;
    repeat (H) @(negedge clk);
    sk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic sendv(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitc(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk); sk = 1'b0; di = 1'b0; cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_dn();
    @(negedge clk); sk = 1'b0; di = 1'b0; cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] v, output bit dummy_ok);
    cs_up();
    sendv(32'b110, 3);
    sendv({23'd0, a}, aw());
    dummy_ok = (sdo_oe === 1'b1) && (sdo === 1'b0);
    v = '0;
    for (int i = 0; i < dw(); i++) begin
      bitc(1'b0);
      v = {v[14:0], sdo};
    end
    cs_dn();
  endtask

  task automatic check_read(input logic [8:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    bit dok;
    rd(a, v, dok);
    chk(dok, {req, " dummy zero before data"}, 32'(dok), 32'd1);
    chk(v === exp, {req, " read data"}, 32'(v), 32'(exp));
  endtask

  // lowers chip select, then polls status
  task automatic finish_prog(input bit expect_st, input string req);
    int t;
    @(negedge clk); sk = 1'b0; di = 1'b0; cs = 1'b0;
    t = 0;
    repeat (6) begin @(negedge clk); t++; end
    cs = 1'b1;
    repeat (4) begin @(negedge clk); t++; end
    if (!expect_st) begin
      chk(sdo_oe === 1'b0, {req, " no status shown"}, 32'(sdo_oe), 32'd0);
      cs_dn();
    end else begin
      chk(sdo_oe === 1'b1 && sdo === 1'b0, {req, " R9 busy reads low"},
          32'({sdo_oe, sdo}), 32'b10);
      while (sdo !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
      chk(t >= OPCY && t <= OPCY + 12, {req, " R9 busy length"}, 32'(t), 32'(OPCY));
      bitc(1'b1);
      chk(sdo_oe === 1'b0, {req, " R10 dummy one releases output"}, 32'(sdo_oe), 32'd0);
      cs_dn();
    end
  endtask

  task automatic wr_frame(input logic [8:0] a, input logic [15:0] d);
    cs_up();
    sendv(32'b101, 3);
    sendv({23'd0, a}, aw());
    sendv({16'd0, d}, dw());
  endtask

  task automatic er_frame(input logic [8:0] a);
    cs_up();
    sendv(32'b111, 3);
    sendv({23'd0, a}, aw());
  endtask

  task automatic sp_frame(input logic [1:0] code);
    cs_up();
    sendv(32'b100, 3);
    if (org_x8) sendv({23'd0, code, 7'b0101010}, 9);
    else sendv({24'd0, code, 6'b110011}, 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit dok;
    rst = 1'b1; org_x8 = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 output released after reset", 32'(sdo_oe), 32'd0);

    // R1: latch clear after reset, write starts nothing
    wr_frame(9'd5, 16'hA5A5);
    finish_prog(1'b0, "R1 write after reset");

    // R6: unlock
    sp_frame(2'b11);
    cs_dn();

    // R3 / R2: table of writes then reads
    for (int i = 0; i < NV; i++) begin
      wr_frame({1'b0, VEC[i][23:16]}, VEC[i][15:0]);
      finish_prog(1'b1, "R3 write");
    end
    for (int i = 0; i < NV; i++) begin
      check_read({1'b0, VEC[i][23:16]}, VEC[i][15:0], "R2 R3 table");
    end
    chk(sdo_oe === 1'b0, "R12 released after read with cs low", 32'(sdo_oe), 32'd0);

    // R6 / R4: lock then try to write
    sp_frame(2'b00);
    cs_dn();
    wr_frame({1'b0, VEC[0][23:16]}, 16'h1234);
    finish_prog(1'b0, "R4 locked write");
    check_read({1'b0, VEC[0][23:16]}, VEC[0][15:0], "R4 locked write kept");
    er_frame({1'b0, VEC[1][23:16]});
    finish_prog(1'b0, "R4 locked erase");
    check_read({1'b0, VEC[1][23:16]}, VEC[1][15:0], "R4 locked erase kept");

    // R5: erase one word
    sp_frame(2'b11);
    cs_dn();
    er_frame({1'b0, VEC[1][23:16]});
    finish_prog(1'b1, "R5 erase");
    check_read({1'b0, VEC[1][23:16]}, 16'hFFFF, "R5 erased word");
    check_read({1'b0, VEC[2][23:16]}, VEC[2][15:0], "R5 neighbour kept");

    // R11: abort inside data field
    cs_up();
    sendv(32'b101, 3);
    sendv({24'd0, VEC[2][23:16]}, 8);
    sendv(32'b10110, 5);
    finish_prog(1'b0, "R11 aborted write");
    check_read({1'b0, VEC[2][23:16]}, VEC[2][15:0], "R11 aborted write kept");
    // R11: abort inside address, then fresh read
    cs_up();
    sendv(32'b110, 3);
    sendv(32'b101, 3);
    cs_dn();
    check_read({1'b0, VEC[3][23:16]}, VEC[3][15:0], "R11 fresh frame after abort");

    // R7: fill all, then wipe all
    cs_up();
    sendv(32'b100, 3);
    sendv({24'd0, 2'b01, 6'b000000}, 8);
    sendv(32'h3C5A, 16);
    finish_prog(1'b1, "R7 fill");
    check_read(9'd0, 16'h3C5A, "R7 fill first word");
    check_read(9'd255, 16'h3C5A, "R7 fill last word");
    sp_frame(2'b10);
    finish_prog(1'b1, "R7 wipe");
    check_read(9'd128, 16'hFFFF, "R7 wipe middle word");
    check_read(9'd0, 16'hFFFF, "R7 wipe first word");

    // R8: byte organisation
    org_x8 = 1'b1;
    repeat (4) @(negedge clk);
    wr_frame(9'd9, 16'h007E);
    finish_prog(1'b1, "R8 byte write");
    check_read(9'd9, 16'h007E, "R8 byte read high half");
    check_read(9'd8, 16'h00FF, "R8 byte read low half");
    sp_frame(2'b00);
    cs_dn();
    wr_frame(9'd8, 16'h0011);
    finish_prog(1'b0, "R8 R6 byte-mode lock");
    sp_frame(2'b11);
    cs_dn();
    wr_frame(9'd8, 16'h00C4);
    finish_prog(1'b1, "R8 R6 byte-mode unlock");
    org_x8 = 1'b0;
    repeat (4) @(negedge clk);
    check_read(9'd4, 16'h7EC4, "R8 word view of bytes 8 and 9");

    // R10: during status, zeros do not release and no instruction starts
    wr_frame(9'd7, 16'h1357);
    @(negedge clk); cs = 1'b0; sk = 1'b0;
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (OPCY + 20) @(negedge clk);
    bitc(1'b0);
    bitc(1'b0);
    chk(sdo_oe === 1'b1 && sdo === 1'b1, "R10 zeros keep ready status",
        32'({sdo_oe, sdo}), 32'b11);
    bitc(1'b1);
    chk(sdo_oe === 1'b0, "R10 dummy one releases", 32'(sdo_oe), 32'd0);
    cs_dn();
    rd(9'd7, v, dok);
    chk(v === 16'h1357, "R10 R3 write behind status", 32'(v), 32'h1357);
    chk(sdo_oe === 1'b0, "R12 idle output released", 32'(sdo_oe), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule